// File: doc/BRIEF.md
# Static Re-Reference Replacement Controller

This block holds the replacement state of a set-associative cache and names the way to evict when a miss needs room. Every way of every set carries a two-bit re-reference prediction value: 0 means the line is expected back soon, 3 means it is expected back far in the future or not at all. Hits, fills and invalidations move a single way's value to a fixed level. A victim request asks for the eviction choice in one set. Tags, data, hit detection and miss handling all sit outside.

Updates arrive on three command channels (invalidate, fill, hit), each with its own enable, set index and way index. At most one update is applied per cycle. Invalidate beats fill, and fill beats hit. A victim request is accepted in the same cycle as an update, and it sees that update. The search result comes back on the cycle after the request, marked by a valid strobe. When no way in the set holds 3, the whole set is aged in one step: each way gains the distance between 3 and the set's largest value. The victim is then the lowest-index way holding 3, and the aged values are written back.

The response path is a two-state machine. ST_IDLE moves to ST_RESP when a victim request arrives. ST_RESP stays in ST_RESP on another request and returns to ST_IDLE otherwise. The valid strobe is high exactly while the machine is in ST_RESP.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset every way of every set holds value 3, and the valid strobe is low.
- R2: A hit applied to a way sets that way's value to 0.
- R3: A fill applied to a way sets that way's value to 2.
- R4: An invalidate applied to a way sets that way's value to 3.
- R5: When the set already has a way at 3, the victim is the lowest-index such way and no stored value changes.
- R6: When no way is at 3, every way of the set gains (3 − the set's largest value), the aged values are stored, and the victim is the lowest-index way now at 3.
- R7: The victim way and a high valid strobe appear on the cycle after each request. The strobe is high for exactly one cycle per request, so back-to-back requests hold it high, and it is low in any cycle not preceded by a request.
- R8: Only one update is applied per cycle. Invalidate beats fill, fill beats hit, and the losing commands have no effect.
- R9: A victim request that shares its cycle and set with the winning update chooses from the values after that update.
- R10: Sets are independent. An update to one set and a victim request to another in the same cycle both take full effect, and a set never touched still reports way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_en | input | 1 | Invalidate command |
| inv_set | input | log2(NUM_SETS) | Set index of the invalidate |
| inv_way | input | log2(NUM_WAYS) | Way index of the invalidate |
| fill_en | input | 1 | Fill command |
| fill_set | input | log2(NUM_SETS) | Set index of the fill |
| fill_way | input | log2(NUM_WAYS) | Way index of the fill |
| hit_en | input | 1 | Hit command |
| hit_set | input | log2(NUM_SETS) | Set index of the hit |
| hit_way | input | log2(NUM_WAYS) | Way index of the hit |
| vic_req | input | 1 | Victim search request |
| vic_set | input | log2(NUM_SETS) | Set to search |
| vic_valid | output | 1 | Victim result valid, one cycle after the request |
| vic_way | output | log2(NUM_WAYS) | Chosen victim way |

## Verification
The bench builds rows where the largest value is 2, 1 and 0. A design that ages by one step only, or that forgets to store the aged values, then returns the wrong way on the next search. It issues colliding invalidate, fill and hit commands on the same way, where the three priority orders leave different values, so a wrong order changes the later victim. It pairs a fill with a same-cycle search of that set, which a design without forwarding answers from stale state. It pairs an update in one set with a search in another, where a shared write port would drop the update. It repeats searches on a row that already holds a 3, where a design that ages anyway would move the victim. Finally it checks a mid-run reset, after which a design that failed to restore every value to 3 picks the wrong way.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    localparam int RRPV_W = 2;
    typedef logic [RRPV_W-1:0] rrpv_t;

    localparam rrpv_t RRPV_DISTANT = 2'd3;
    localparam rrpv_t RRPV_INSERT  = 2'd2;
    localparam rrpv_t RRPV_NEAR    = 2'd0;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_HIT  = 2'd1,
        UPD_FILL = 2'd2,
        UPD_INV  = 2'd3
    } upd_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

    function automatic rrpv_t kind_to_value(upd_kind_e kind);
        rrpv_t v;
        unique case (kind)
            UPD_HIT:  v = RRPV_NEAR;
            UPD_FILL: v = RRPV_INSERT;
            default:  v = RRPV_DISTANT;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rrip_upd_arb.sv
module rrip_upd_arb
    import rrip_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int WAY_W = 2
) (
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    output upd_kind_e        upd_kind,
    output logic             upd_en,
    output logic [SET_W-1:0] upd_set,
    output logic [WAY_W-1:0] upd_way,
    output rrpv_t            upd_val
);

    // fixed priority: invalidate, then fill, then hit
    always_comb begin
        upd_kind = UPD_NONE;
        upd_set  = '0;
        upd_way  = '0;
        if (inv_en) begin
            upd_kind = UPD_INV;
            upd_set  = inv_set;
            upd_way  = inv_way;
        end else if (fill_en) begin
            upd_kind = UPD_FILL;
            upd_set  = fill_set;
            upd_way  = fill_way;
        end else if (hit_en) begin
            upd_kind = UPD_HIT;
            upd_set  = hit_set;
            upd_way  = hit_way;
        end
    end

    assign upd_en  = (upd_kind != UPD_NONE);
    assign upd_val = kind_to_value(upd_kind);

endmodule

// File: rtl/rrip_age_unit.sv
module rrip_age_unit
    import rrip_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  rrpv_t [NUM_WAYS-1:0] cur_row,
    output rrpv_t [NUM_WAYS-1:0] aged_row,
    output logic  [WAY_W-1:0]    victim_way
);

    rrpv_t row_max;
    rrpv_t shift_amt;

    always_comb begin
        row_max = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (cur_row[w] > row_max) row_max = cur_row[w];
        end
    end

    assign shift_amt = RRPV_DISTANT - row_max;

    // one-step aging: the largest value lands exactly on the distant level
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_age
        assign aged_row[g] = cur_row[g] + shift_amt;
    end

    // scan from the top down so the lowest matching index is kept
    always_comb begin
        victim_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (aged_row[w] == RRPV_DISTANT) victim_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/rrip_state_bank.sv
module rrip_state_bank
    import rrip_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SET_W-1:0]     rd_set,
    output rrpv_t [NUM_WAYS-1:0] rd_row,
    input  logic                 upd_en,
    input  logic [SET_W-1:0]     upd_set,
    input  logic [WAY_W-1:0]     upd_way,
    input  rrpv_t                upd_val,
    input  logic                 age_en,
    input  logic [SET_W-1:0]     age_set,
    input  rrpv_t [NUM_WAYS-1:0] age_row
);

    rrpv_t [NUM_WAYS-1:0] bank_q [NUM_SETS];
    logic                 upd_alone;

    // a whole-row write to the same set already carries the update
    assign upd_alone = upd_en && !(age_en && (age_set == upd_set));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    bank_q[s][w] <= RRPV_DISTANT;
                end
            end
        end else begin
            if (upd_alone) bank_q[upd_set][upd_way] <= upd_val;
            if (age_en)    bank_q[age_set]          <= age_row;
        end
    end

    assign rd_row = bank_q[rd_set];

    AST_UPD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_alone |=> bank_q[$past(upd_set)][$past(upd_way)] == $past(upd_val)); // R2

    AST_AGE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        age_en |=> bank_q[$past(age_set)] == $past(age_row)); // R6

endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl
    import rrip_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way
);

    upd_kind_e            upd_kind;
    logic                 upd_en;
    logic [SET_W-1:0]     upd_set;
    logic [WAY_W-1:0]     upd_way;
    rrpv_t                upd_val;
    rrpv_t [NUM_WAYS-1:0] stored_row;
    rrpv_t [NUM_WAYS-1:0] fwd_row;
    rrpv_t [NUM_WAYS-1:0] aged_row;
    logic  [WAY_W-1:0]    age_victim;
    resp_state_e          state_q;
    resp_state_e          state_d;
    logic  [WAY_W-1:0]    vic_way_q;

    rrip_upd_arb #(.SET_W(SET_W), .WAY_W(WAY_W)) u_arb (
        .inv_en   (inv_en),
        .inv_set  (inv_set),
        .inv_way  (inv_way),
        .fill_en  (fill_en),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .hit_en   (hit_en),
        .hit_set  (hit_set),
        .hit_way  (hit_way),
        .upd_kind (upd_kind),
        .upd_en   (upd_en),
        .upd_set  (upd_set),
        .upd_way  (upd_way),
        .upd_val  (upd_val)
    );

    rrip_state_bank #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .SET_W    (SET_W),
        .WAY_W    (WAY_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (vic_set),
        .rd_row  (stored_row),
        .upd_en  (upd_en),
        .upd_set (upd_set),
        .upd_way (upd_way),
        .upd_val (upd_val),
        .age_en  (vic_req),
        .age_set (vic_set),
        .age_row (aged_row)
    );

    // same-cycle update to the searched set is seen by the search
    always_comb begin
        fwd_row = stored_row;
        if (upd_en && (upd_set == vic_set)) fwd_row[upd_way] = upd_val;
    end

    rrip_age_unit #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_age (
        .cur_row    (fwd_row),
        .aged_row   (aged_row),
        .victim_way (age_victim)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (vic_req) state_d = ST_RESP;
            ST_RESP: state_d = vic_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            vic_way_q <= '0;
        end else begin
            state_q <= state_d;
            if (vic_req) vic_way_q <= age_victim;
        end
    end

    // outputs
    always_comb begin
        vic_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: vic_valid = 1'b0;
            ST_RESP: vic_valid = 1'b1;
            default: vic_valid = 1'b0;
        endcase
        vic_way = vic_way_q;
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_valid); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_valid); // R7

    AST_VICTIM_DISTANT: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |-> aged_row[age_victim] == RRPV_DISTANT); // R6

    AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> (upd_kind == UPD_INV) && (upd_set == inv_set) && (upd_way == inv_way)); // R8

    AST_FILL_OVER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en) |-> (upd_kind == UPD_FILL) && (upd_way == fill_way)); // R8

endmodule

// File: tb/rrip_repl_ctrl_tb_top.sv
`timescale 1ns/1ps
module rrip_repl_ctrl_tb_top;

    localparam int NSETS = 64;
    localparam int NWAYS = 4;
    localparam int SW    = 6;
    localparam int WW    = 2;

    // vector: [15:14] op (0 hit, 1 fill, 2 invalidate, 3 victim),
    //         [13:8] set, [7:6] way, [5:4] expected victim, [3:0] requirement
    localparam int NVEC = 31;
    localparam logic [15:0] VEC [NVEC] = '{
        {2'd3, 6'd5,  2'd0, 2'd0, 4'd5},  // R5 fresh set, no aging
        {2'd1, 6'd5,  2'd0, 2'd0, 4'd3},  // R3 fill w0 -> 2
        {2'd3, 6'd5,  2'd0, 2'd1, 4'd3},  // R3 w0 no longer at 3
        {2'd1, 6'd5,  2'd1, 2'd0, 4'd3},
        {2'd1, 6'd5,  2'd2, 2'd0, 4'd3},
        {2'd1, 6'd5,  2'd3, 2'd0, 4'd3},  // row 2,2,2,2
        {2'd3, 6'd5,  2'd0, 2'd0, 4'd6},  // R6 max 2, all to 3
        {2'd1, 6'd5,  2'd0, 2'd0, 4'd3},
        {2'd0, 6'd5,  2'd1, 2'd0, 4'd2},  // R2
        {2'd0, 6'd5,  2'd2, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd3, 2'd0, 4'd2},  // row 2,0,0,0
        {2'd3, 6'd5,  2'd0, 2'd0, 4'd6},  // R6 -> 3,1,1,1
        {2'd0, 6'd5,  2'd0, 2'd0, 4'd2},  // row 0,1,1,1
        {2'd3, 6'd5,  2'd0, 2'd1, 4'd6},  // R6 shift 2 -> 2,3,3,3
        {2'd0, 6'd5,  2'd1, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd2, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd3, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd0, 2'd0, 4'd2},  // row 0,0,0,0
        {2'd3, 6'd5,  2'd0, 2'd0, 4'd6},  // R6 shift 3
        {2'd0, 6'd5,  2'd0, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd1, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd2, 2'd0, 4'd2},
        {2'd0, 6'd5,  2'd3, 2'd0, 4'd2},
        {2'd2, 6'd5,  2'd2, 2'd0, 4'd4},  // R4 row 0,0,3,0
        {2'd3, 6'd5,  2'd0, 2'd2, 4'd4},
        {2'd3, 6'd5,  2'd0, 2'd2, 4'd5},  // R5 row unchanged
        {2'd3, 6'd6,  2'd0, 2'd0, 4'd10}, // R10 untouched set
        {2'd1, 6'd63, 2'd0, 2'd0, 4'd3},
        {2'd1, 6'd63, 2'd1, 2'd0, 4'd3},
        {2'd1, 6'd63, 2'd2, 2'd0, 4'd3},
        {2'd3, 6'd63, 2'd0, 2'd3, 4'd5}   // R5 last set
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          inv_en, fill_en, hit_en, vic_req;
    logic [SW-1:0] inv_set, fill_set, hit_set, vic_set;
    logic [WW-1:0] inv_way, fill_way, hit_way;
    logic          vic_valid;
    logic [WW-1:0] vic_way;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rrip_repl_ctrl #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_en   (inv_en),
        .inv_set  (inv_set),
        .inv_way  (inv_way),
        .fill_en  (fill_en),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .hit_en   (hit_en),
        .hit_set  (hit_set),
        .hit_way  (hit_way),
        .vic_req  (vic_req),
        .vic_set  (vic_set),
        .vic_valid(vic_valid),
        .vic_way  (vic_way)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        inv_en = 0; fill_en = 0; hit_en = 0; vic_req = 0;
        inv_set = '0; fill_set = '0; hit_set = '0; vic_set = '0;
        inv_way = '0; fill_way = '0; hit_way = '0;
    endtask

    // one command cycle: drive on a falling edge, sample on the next one
    task automatic run_op(input int op, input int s, input int w);
        idle_inputs();
        case (op)
            0: begin hit_en  = 1; hit_set  = SW'(s); hit_way  = WW'(w); end
            1: begin fill_en = 1; fill_set = SW'(s); fill_way = WW'(w); end
            2: begin inv_en  = 1; inv_set  = SW'(s); inv_way  = WW'(w); end
            default: begin vic_req = 1; vic_set = SW'(s); end
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic victim_chk(input string req, input int s, input int exp);
        run_op(3, s, 0);
        chk(req, int'(vic_valid), 1);
        chk(req, int'(vic_way), exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 valid low after reset", int'(vic_valid), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            run_op(int'(v[15:14]), int'(v[13:8]), int'(v[7:6]));
            if (v[15:14] == 2'd3) begin
                chk($sformatf("R%0d vec %0d valid", v[3:0], i), int'(vic_valid), 1);
                chk($sformatf("R%0d vec %0d way", v[3:0], i), int'(vic_way), int'(v[5:4]));
            end else begin
                chk($sformatf("R7 vec %0d no strobe", i), int'(vic_valid), 0);
            end
        end

        // R8 fill beats hit on the same way
        for (int w = 0; w < NWAYS; w++) run_op(1, 10, w);
        idle_inputs();
        fill_en = 1; fill_set = 6'd10; fill_way = 2'd0;
        hit_en  = 1; hit_set  = 6'd10; hit_way  = 2'd0;
        @(negedge clk);
        idle_inputs();
        victim_chk("R8 fill over hit", 10, 0);

        // R8 invalidate beats fill on the same way
        for (int w = 0; w < NWAYS; w++) run_op(1, 11, w);
        idle_inputs();
        inv_en  = 1; inv_set  = 6'd11; inv_way  = 2'd2;
        fill_en = 1; fill_set = 6'd11; fill_way = 2'd2;
        @(negedge clk);
        idle_inputs();
        victim_chk("R8 invalidate over fill", 11, 2);

        // R8 losing hit elsewhere has no effect
        for (int w = 0; w < NWAYS; w++) run_op(1, 15, w);
        idle_inputs();
        fill_en = 1; fill_set = 6'd16; fill_way = 2'd0;
        hit_en  = 1; hit_set  = 6'd15; hit_way  = 2'd0;
        @(negedge clk);
        idle_inputs();
        victim_chk("R8 dropped hit", 15, 0);

        // R9 fill and search of the same set in one cycle
        idle_inputs();
        fill_en = 1; fill_set = 6'd12; fill_way = 2'd0;
        vic_req = 1; vic_set  = 6'd12;
        @(negedge clk);
        idle_inputs();
        chk("R9 valid", int'(vic_valid), 1);
        chk("R9 forwarded way", int'(vic_way), 1);

        // R10 update and search in different sets together
        idle_inputs();
        hit_en  = 1; hit_set = 6'd13; hit_way = 2'd0;
        vic_req = 1; vic_set = 6'd14;
        @(negedge clk);
        idle_inputs();
        chk("R10 other set way", int'(vic_way), 0);
        victim_chk("R10 hit kept", 13, 1);

        // R1 mid-run reset restores distant values
        do_reset();
        chk("R1 valid low after second reset", int'(vic_valid), 0);
        run_op(1, 5, 0);
        victim_chk("R1 values restored", 5, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule